// File: doc/BRIEF.md
# Chip-Enable Latched Static Memory

This block is a synthesizable behavioural model of a byte-wide static memory whose address is captured into internal registers when the active-low chip enable falls. It is not decoded combinationally from the address pins. A fast reference clock samples every control pin, so all edge detection stays synchronous to that clock. The bidirectional data bus is split into a data input, a data output and an output-drive enable, and a surrounding pad or tristate stage uses those three signals.

A cycle begins when chip enable falls. During a read, the model drives the word at the captured address while output enable is low and write enable stays high. During a write, write enable goes low and the cycle ends at the first rising edge of either write enable or chip enable. The model stores the byte that was on the bus just before that terminating edge. Holding write enable low across several chip-enable cycles writes one location per cycle. A separate flag marks the pin state in which an external driver and the memory could fight over the bus.

Top module: `sram_cel_top`

## Requirements
- R1: The array holds 2^ADDR_W words of DATA_W bits (default 2048 x 8). A word written at one address is read back unchanged after every other address has been written.
- R2: The address is taken from the first reference-clock sample that sees chip enable low after it was high. The address pins may change one clock after that edge, and any later change in the same cycle has no effect on which word is read or written.
- R3: With chip enable low, output enable low and write enable high, dataOe is 1 and dataOut equals the word at the captured address no later than 3 reference clocks after the last of these conditions became true. This includes a word written earlier in the same cycle.
- R4: Output enable high forces dataOe to 0 within 2 reference clocks, whatever chip enable is doing.
- R5: Chip enable returning high forces dataOe to 0 within 2 reference clocks.
- R6: A write is stored once, at the first rising edge of write enable or chip enable. The stored byte is the one sampled at the last clock while write enable was still low. A byte that appears together with the terminating edge is not stored.
- R7: Once write enable has risen, a later rise of chip enable in the same cycle stores nothing, even if the data pins have changed.
- R8: With write enable held low across several chip-enable cycles, each cycle writes its own captured address with the byte present when chip enable rises.
- R9: While write enable is low, dataOe stays 0. A write performed with output enable held high never asserts dataOe.
- R10: busConflict is 1 exactly when chip enable, output enable and write enable are all sampled low, with 2 reference clocks of latency. It is never 1 in the same clock as dataOe.
- R11: During and right after reset, dataOe, dataOut and busConflict are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Reference sampling clock |
| rstN | input | 1 | Active-low asynchronous reset |
| addrIn | input | ADDR_W | Address pins, captured when chip enable falls |
| ceN | input | 1 | Active-low chip enable; its fall starts a cycle |
| weN | input | 1 | Active-low write enable |
| oeN | input | 1 | Active-low output enable |
| dataIn | input | DATA_W | Write data as seen on the bus |
| dataOut | output | DATA_W | Read data toward the bus |
| dataOe | output | 1 | Bus drive enable for dataOut |
| busConflict | output | 1 | Chip, output and write enables all low |

## Verification
The bench builds the block with ADDR_W = 6 and DATA_W = 8. The whole 64-word array then fits in a short run, so every location can be written in one chain of chip-enable cycles with write enable held low and then read back. That run exposes aliasing or lost address bits that a few spot writes would miss. The 8-bit width keeps the patterns that change data together with a terminating edge distinguishable byte by byte.

// File: rtl/sram_cel_pkg.sv
package sram_cel_pkg;

  // Strobes from the control sequencer to the storage datapath
  typedef struct packed {
    logic capAddr;  // take the sampled address into the cycle register
    logic wrEn;     // commit the held write byte at the captured address
    logic driveEn;  // enable the bus driver on the next clock
  } memStrobes_t;

endpackage

// File: rtl/sram_cel_ctrl.sv
module sram_cel_ctrl
  import sram_cel_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        ceN,
  input  logic        weN,
  input  logic        oeN,
  output memStrobes_t strobes,
  output logic        busConflict
);

  // First sample stage and one-clock history of the control pins
  logic ceQ, weQ, oeQ;
  logic ceQQ, weQQ;
  logic cycleValid;
  logic ceFall, ceRise, weRise;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      ceQ  <= 1'b1;
      weQ  <= 1'b1;
      oeQ  <= 1'b1;
      ceQQ <= 1'b1;
      weQQ <= 1'b1;
    end else begin
      ceQ  <= ceN;
      weQ  <= weN;
      oeQ  <= oeN;
      ceQQ <= ceQ;
      weQQ <= weQ;
    end
  end

  assign ceFall = ceQQ & ~ceQ;
  assign ceRise = ~ceQQ & ceQ;
  assign weRise = ~weQQ & weQ;

  // A cycle is open from a detected enable fall until enable is seen high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      cycleValid <= 1'b0;
    else if (ceFall)
      cycleValid <= 1'b1;
    else if (ceQ)
      cycleValid <= 1'b0;
  end

  always_comb begin
    strobes         = '0;
    strobes.capAddr = ceFall;
    // The first rising edge of either enable ends a write that was armed
    strobes.wrEn    = cycleValid & ~weQQ & (weRise | ceRise);
    // Drive only in an open cycle with output enabled and write released
    strobes.driveEn = cycleValid & ~ceQ & ~oeQ & weQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)
      busConflict <= 1'b0;
    else
      busConflict <= ~ceQ & ~oeQ & ~weQ;
  end

  // R6
  write_once_chk: assert property (@(posedge clk) disable iff (!rstN)
    strobes.wrEn |=> !strobes.wrEn);

  // R2
  cycle_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cycleValid && !ceQ) |=> cycleValid);

endmodule

// File: rtl/sram_cel_datapath.sv
module sram_cel_datapath
  import sram_cel_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic [DATA_W-1:0] dataIn,
  input  memStrobes_t       strobes,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] addrQ;
  logic [ADDR_W-1:0] latchedAddr;
  logic [DATA_W-1:0] dataQ;
  logic [DATA_W-1:0] dataQQ;
  logic [DATA_W-1:0] memArray [DEPTH];

  // Sample stages aligned with the control sampling
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      addrQ       <= '0;
      dataQ       <= '0;
      dataQQ      <= '0;
      latchedAddr <= '0;
    end else begin
      addrQ  <= addrIn;
      dataQ  <= dataIn;
      dataQQ <= dataQ;
      if (strobes.capAddr)
        latchedAddr <= addrQ;
    end
  end

  // Storage array; held byte is the last one sampled with write low
  always_ff @(posedge clk) begin
    if (strobes.wrEn)
      memArray[latchedAddr] <= dataQQ;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataOut <= '0;
      dataOe  <= 1'b0;
    end else begin
      dataOut <= memArray[latchedAddr];
      dataOe  <= strobes.driveEn;
    end
  end

  // R2
  addr_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(strobes.capAddr) |-> $stable(latchedAddr));

endmodule

// File: rtl/sram_cel_top.sv
module sram_cel_top
  import sram_cel_pkg::*;
#(
  parameter int ADDR_W = 11,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] addrIn,
  input  logic              ceN,
  input  logic              weN,
  input  logic              oeN,
  input  logic [DATA_W-1:0] dataIn,
  output logic [DATA_W-1:0] dataOut,
  output logic              dataOe,
  output logic              busConflict
);

  memStrobes_t strobes;

  sram_cel_ctrl ctrl_i (
    .clk         (clk),
    .rstN        (rstN),
    .ceN         (ceN),
    .weN         (weN),
    .oeN         (oeN),
    .strobes     (strobes),
    .busConflict (busConflict)
  );

  sram_cel_datapath #(
    .ADDR_W (ADDR_W),
    .DATA_W (DATA_W)
  ) datapath_i (
    .clk     (clk),
    .rstN    (rstN),
    .addrIn  (addrIn),
    .dataIn  (dataIn),
    .strobes (strobes),
    .dataOut (dataOut),
    .dataOe  (dataOe)
  );

  // R9
  drive_gate_chk: assert property (@(posedge clk) disable iff (!rstN)
    dataOe |-> ($past(weN, 2) && !$past(oeN, 2) && !$past(ceN, 2)));

  // R10
  conflict_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    busConflict |-> !dataOe);

endmodule

// File: tb/sram_cel_top_tb_top.sv
`timescale 1ns/1ps
module sram_cel_top_tb_top;

  localparam int AW = 6;
  localparam int DW = 8;
  localparam int NW = 1 << AW;

  typedef struct {
    string         req;
    logic [DW-1:0] val;
  } expItem_t;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic [AW-1:0] addrIn = '0;
  logic          ceN = 1'b1;
  logic          weN = 1'b1;
  logic          oeN = 1'b1;
  logic [DW-1:0] dataIn = '0;
  logic [DW-1:0] dataOut;
  logic          dataOe;
  logic          busConflict;

  expItem_t      expQ[$];
  event          sampleEv;
  int            checks = 0;
  int            errors = 0;
  bit            finished = 1'b0;
  bit            watchOe = 1'b0;
  bit            sawOe = 1'b0;
  logic [DW-1:0] model [NW];

  always #10 clk = ~clk;

  sram_cel_top #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
    .clk(clk), .rstN(rstN), .addrIn(addrIn), .ceN(ceN), .weN(weN),
    .oeN(oeN), .dataIn(dataIn), .dataOut(dataOut), .dataOe(dataOe),
    .busConflict(busConflict)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Monitor: pops the scoreboard whenever the driver marks a sample point
  initial begin
    forever begin
      @(sampleEv);
      if (expQ.size() == 0) begin
        checks++;
        errors++;
        $display("FAIL R3 scoreboard empty actual=sample expected=item");
      end else begin
        expItem_t item;
        item = expQ.pop_front();
        check(item.req, {23'd0, dataOe, dataOut}, {23'd0, 1'b1, item.val});
      end
    end
  end

  initial begin
    forever begin
      @(negedge clk);
      if (watchOe && dataOe) sawOe = 1'b1;
    end
  end

  task automatic writeWord(input logic [AW-1:0] a, input logic [DW-1:0] d);
    addrIn = a; dataIn = d; ceN = 1'b0;
    tick(2);
    weN = 1'b0;
    tick(2);
    weN = 1'b1;
    tick(2);
    ceN = 1'b1;
    tick(3);
    model[a] = d;
  endtask

  task automatic readWord(input logic [AW-1:0] a, input string req);
    addrIn = a; ceN = 1'b0; oeN = 1'b0; weN = 1'b1;
    tick(2);
    addrIn = ~a;  // R2: later address change must not matter
    tick(3);
    expQ.push_back('{req, model[a]});
    ->sampleEv;
    tick(1);
    ceN = 1'b1; oeN = 1'b1;
    tick(3);
    check("R5 drive released after cycle", {31'd0, dataOe}, 32'd0);
  endtask

  initial begin
    tick(3);
    check("R11 dataOe in reset", {31'd0, dataOe}, 32'd0);
    check("R11 dataOut in reset", {24'd0, dataOut}, 32'd0);
    rstN = 1'b1;
    tick(3);
    check("R11 busConflict after reset", {31'd0, busConflict}, 32'd0);
    check("R11 dataOe after reset", {31'd0, dataOe}, 32'd0);

    // Spot writes and reads, output enable high during writes (R9)
    watchOe = 1'b1;
    writeWord(6'd3, 8'hA5);
    writeWord(6'd9, 8'h3C);
    writeWord(6'd62, 8'h81);
    watchOe = 1'b0;
    check("R9 no drive during write with output disabled", {31'd0, sawOe}, 32'd0);
    readWord(6'd3, "R3 read spot word 3");
    readWord(6'd9, "R2 read spot word 9 with address moved");
    readWord(6'd62, "R3 read spot word 62");

    // R8: write enable held low across a chain of enable cycles
    weN = 1'b0;
    for (int i = 0; i < NW; i++) begin
      addrIn = i[AW-1:0];
      dataIn = 8'(i * 37 + 5);
      ceN = 1'b0;
      tick(3);
      if (i == 0) check("R10 no conflict with output disabled", {31'd0, busConflict}, 32'd0);
      ceN = 1'b1;
      tick(3);
      model[i] = 8'(i * 37 + 5);
    end
    weN = 1'b1;
    tick(2);
    for (int i = 0; i < NW; i++) readWord(i[AW-1:0], "R1 R8 full array readback");

    // R6: data changing together with write release is not stored
    addrIn = 6'd5; dataIn = 8'h11; ceN = 1'b0;
    tick(2);
    weN = 1'b0;
    tick(3);
    weN = 1'b1; dataIn = 8'hEE;
    tick(3);
    ceN = 1'b1;
    tick(3);
    model[5] = 8'h11;
    readWord(6'd5, "R6 write ended by write enable");

    // R7: enable rise after write release stores nothing
    addrIn = 6'd6; dataIn = 8'h22; ceN = 1'b0;
    tick(2);
    weN = 1'b0;
    tick(3);
    weN = 1'b1;
    tick(3);
    dataIn = 8'hDD;
    tick(2);
    ceN = 1'b1;
    tick(3);
    model[6] = 8'h22;
    readWord(6'd6, "R7 late enable rise ignored");

    // R6: write ended by chip enable, data changing with that edge
    addrIn = 6'd7; dataIn = 8'h33; ceN = 1'b0;
    tick(2);
    weN = 1'b0;
    tick(3);
    ceN = 1'b1; dataIn = 8'hCC;
    tick(2);
    weN = 1'b1;
    tick(3);
    model[7] = 8'h33;
    readWord(6'd7, "R6 write ended by chip enable");

    // R9 R10 R3 R4 R5: all enables low, then release write
    addrIn = 6'd10; dataIn = 8'h5A; ceN = 1'b0; oeN = 1'b0; weN = 1'b0;
    tick(3);
    check("R9 no drive while write low", {31'd0, dataOe}, 32'd0);
    check("R10 conflict flagged", {31'd0, busConflict}, 32'd1);
    weN = 1'b1;
    tick(3);
    check("R10 conflict cleared", {31'd0, busConflict}, 32'd0);
    check("R3 written word driven in same cycle", {23'd0, dataOe, dataOut}, {23'd0, 1'b1, 8'h5A});
    model[10] = 8'h5A;
    oeN = 1'b1;
    tick(2);
    check("R4 output enable high blocks drive", {31'd0, dataOe}, 32'd0);
    oeN = 1'b0;
    tick(3);
    check("R3 drive restored", {31'd0, dataOe}, 32'd1);
    ceN = 1'b1;
    tick(2);
    check("R5 chip enable high stops drive", {31'd0, dataOe}, 32'd0);
    oeN = 1'b1;
    tick(3);
    readWord(6'd10, "R3 read back conflict-cycle word");
    readWord(6'd3, "R1 earlier word survives");

    tick(5);
    if (expQ.size() != 0) begin
      checks++;
      errors++;
      $display("FAIL R3 scoreboard leftover actual=%0d expected=0", expQ.size());
    end
    finished = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    #(200000 * 20);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL R1 watchdog expired actual=running expected=done");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

endmodule